// File: doc/BRIEF.md
# Burst CRC Checker with Sticky Command Error

This block is the receiving-side integrity engine for a parallel data burst in which every data-carrying strobe edge moves one 16-bit word. When a burst opens it loads a fixed seed into a 16-bit CRC register. It then folds each transferred word into that register in a single cycle, using the generator x^16 + x^12 + x^5 + 1 with the word's most significant bit entering first. When the burst closes, the CRC word the sender placed on the data bus is captured and compared against the local result.

Every mismatch is remembered for the current command. A later clean burst cannot clear it. The index of the first failing burst is kept, and when the command finishes the result is published as two bits of an 8-bit error word. A word counter tracks the expected transfer length. On outbound transfers it marks surplus words as discarded, but those words still enter the CRC.

Top module: `burst_crc_chk`

## Requirements
- R1: Each effective word (word_valid high, term_ack low) updates crc_value on the next edge to the CRC of the prior value and word_data, with polynomial 0x1021, word bit 15 entering first and no final inversion.
- R2: burst_start loads crc_value with 0x4ABA on the next edge. If word_valid is high in the same cycle, the word is applied on top of the seed.
- R3: A word_valid arriving while term_ack is high is ignored. The CRC is unchanged, the word count is unchanged, and neither word_accept nor word_discard rises.
- R4: A crc_cap pulse compares host_crc with crc_value. burst_mismatch is high for exactly the following cycle if and only if the two differ.
- R5: err_sticky rises on the edge after a mismatch. Later clean bursts do not clear it, and only cmd_start (or reset) does.
- R6: first_err_burst holds the 1-based index, counted from cmd_start, of the first failing burst in the command. Later failures leave it unchanged.
- R7: A cmd_end pulse loads err_reg on the next edge with bit 7 and bit 2 both equal to err_sticky and all other bits zero. cmd_start clears err_reg to 0.
- R8: When dir_out is 1 and count_reached is high, an effective word raises word_discard instead of word_accept, and it still updates the CRC.
- R9: count_reached is high when the number of effective words counted since cmd_start is at least xfer_len. Counting stops at xfer_len. When dir_out is 0, every effective word raises word_accept.
- R10: After reset, crc_value is 0x4ABA and burst_mismatch, err_sticky, first_err_burst and err_reg are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command begins; clears error state and counts |
| cmd_end | input | 1 | Command completes; publishes err_reg |
| burst_start | input | 1 | Burst begins; loads the seed |
| dir_out | input | 1 | 1 = outbound (data toward this device) transfer |
| xfer_len | input | 12 | Expected words for the command |
| word_valid | input | 1 | A strobe edge carried a word this cycle |
| term_ack | input | 1 | Termination acknowledged; the strobe edge carries no data |
| word_data | input | 16 | Transferred word |
| crc_cap | input | 1 | Burst end; host_crc holds the sender's CRC |
| host_crc | input | 16 | Sender's CRC from the data bus |
| crc_value | output | 16 | Running CRC register |
| word_accept | output | 1 | Word is passed to the sink this cycle |
| word_discard | output | 1 | Word is surplus and dropped this cycle |
| count_reached | output | 1 | Transfer length reached |
| burst_mismatch | output | 1 | One-cycle pulse after a failed compare |
| err_sticky | output | 1 | Command-level CRC error flag |
| first_err_burst | output | 4 | Index of the first failing burst |
| err_reg | output | 8 | Error word published at command end |

## Verification
On every cycle the assertions check several things: the seed after a lone burst start, CRC stability on idle cycles and on terminating strobe edges, that accept and discard are mutually exclusive, that the sticky flag and the first-error index persist, and that the error word has its fixed two-bit shape. Only the bench scenarios can show that the CRC values themselves are correct. The bench compares them against an independent arithmetic model across swept word patterns and burst lengths. It also shows that the first failing burst is the one reported when several fail, and that surplus outbound words are dropped at exactly the programmed length.

// File: rtl/bcrc_pkg.sv
package bcrc_pkg;
   localparam int unsigned DEF_CRC_W = 16;
   localparam logic [15:0] DEF_POLY  = 16'h1021;
   localparam logic [15:0] DEF_SEED  = 16'h4ABA;

   typedef enum logic [1:0] {
      FATE_NONE    = 2'd0,
      FATE_ACCEPT  = 2'd1,
      FATE_DISCARD = 2'd2,
      FATE_IGNORED = 2'd3
   } word_fate_e;
endpackage

// File: rtl/bcrc_engine.sv
module bcrc_engine #(
   parameter int unsigned CRC_W = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021,
   parameter logic [CRC_W-1:0] SEED = 16'h4ABA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_seed,
   input  logic             fold_en,
   input  logic [CRC_W-1:0] word_in,
   output logic [CRC_W-1:0] crc_q
);
   logic [CRC_W-1:0] base;
   logic [CRC_W-1:0] stage [CRC_W+1];

   assign base     = load_seed ? SEED : crc_q;
   assign stage[0] = base;

   // Unrolled serial divider: one stage per data bit, MSB first.
   for (genvar i = 0; i < CRC_W; i++) begin : g_stage
      logic fb;
      assign fb = stage[i][CRC_W-1] ^ word_in[CRC_W-1-i];
      assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= SEED;
      end else if (fold_en) begin
         crc_q <= stage[CRC_W];
      end else if (load_seed) begin
         crc_q <= SEED;
      end
   end
endmodule

// File: rtl/bcrc_word_gate.sv
module bcrc_word_gate
   import bcrc_pkg::*;
#(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             word_valid,
   input  logic             term_ack,
   input  logic             dir_out,
   input  logic [CNT_W-1:0] xfer_len,
   output word_fate_e       fate,
   output logic             fold_en,
   output logic             reached
);
   logic [CNT_W-1:0] cnt_q;
   logic             eff;

   assign eff     = word_valid & ~term_ack;
   assign reached = (cnt_q >= xfer_len);
   assign fold_en = eff;

   always_comb begin
      if (!word_valid)          fate = FATE_NONE;
      else if (term_ack)        fate = FATE_IGNORED;
      else if (dir_out && reached) fate = FATE_DISCARD;
      else                      fate = FATE_ACCEPT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (eff && !reached) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/bcrc_err_track.sv
module bcrc_err_track #(
   parameter int unsigned CRC_W     = 16,
   parameter int unsigned BURST_W   = 4,
   parameter int unsigned ERR_W     = 8,
   parameter int unsigned ICRC_BIT  = 7,
   parameter int unsigned ABORT_BIT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_start,
   input  logic               cmd_end,
   input  logic               burst_start,
   input  logic               crc_cap,
   input  logic [CRC_W-1:0]   host_crc,
   input  logic [CRC_W-1:0]   crc_local,
   output logic               mismatch_q,
   output logic               sticky_q,
   output logic [BURST_W-1:0] first_q,
   output logic [ERR_W-1:0]   err_q
);
   localparam logic [BURST_W-1:0] BURST_MAX = {BURST_W{1'b1}};

   logic [BURST_W-1:0] burst_cnt_q;
   logic [ERR_W-1:0]   err_next;
   logic               miss;

   assign miss = crc_cap && (host_crc != crc_local);

   for (genvar b = 0; b < ERR_W; b++) begin : g_err_bit
      if (b == ICRC_BIT || b == ABORT_BIT) begin : g_flag
         assign err_next[b] = sticky_q;
      end else begin : g_zero
         assign err_next[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mismatch_q  <= 1'b0;
         sticky_q    <= 1'b0;
         first_q     <= '0;
         err_q       <= '0;
         burst_cnt_q <= '0;
      end else if (cmd_start) begin
         mismatch_q  <= 1'b0;
         sticky_q    <= 1'b0;
         first_q     <= '0;
         err_q       <= '0;
         burst_cnt_q <= '0;
      end else begin
         mismatch_q <= miss;
         if (burst_start && burst_cnt_q != BURST_MAX) begin
            burst_cnt_q <= burst_cnt_q + 1'b1;
         end
         if (miss && !sticky_q) begin
            sticky_q <= 1'b1;
            first_q  <= burst_cnt_q;
         end
         if (cmd_end) begin
            err_q <= err_next;
         end
      end
   end
endmodule

// File: rtl/burst_crc_chk.sv
module burst_crc_chk
   import bcrc_pkg::*;
#(
   parameter int unsigned CRC_W     = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021,
   parameter logic [CRC_W-1:0] SEED = 16'h4ABA,
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned BURST_W   = 4,
   parameter int unsigned ERR_W     = 8,
   parameter int unsigned ICRC_BIT  = 7,
   parameter int unsigned ABORT_BIT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_start,
   input  logic               cmd_end,
   input  logic               burst_start,
   input  logic               dir_out,
   input  logic [CNT_W-1:0]   xfer_len,
   input  logic               word_valid,
   input  logic               term_ack,
   input  logic [CRC_W-1:0]   word_data,
   input  logic               crc_cap,
   input  logic [CRC_W-1:0]   host_crc,
   output logic [CRC_W-1:0]   crc_value,
   output logic               word_accept,
   output logic               word_discard,
   output logic               count_reached,
   output logic               burst_mismatch,
   output logic               err_sticky,
   output logic [BURST_W-1:0] first_err_burst,
   output logic [ERR_W-1:0]   err_reg
);
   initial begin
      assert (CRC_W >= 2) else $fatal(1, "CRC_W must be at least 2");
      assert (BURST_W >= 1) else $fatal(1, "BURST_W must be at least 1");
      assert (ICRC_BIT < ERR_W && ABORT_BIT < ERR_W)
         else $fatal(1, "error bit positions exceed ERR_W");
      assert (ICRC_BIT != ABORT_BIT) else $fatal(1, "error bits must differ");
   end

   word_fate_e fate;
   logic       fold_en;

   bcrc_word_gate #(.CNT_W(CNT_W)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (cmd_start),
      .word_valid (word_valid),
      .term_ack   (term_ack),
      .dir_out    (dir_out),
      .xfer_len   (xfer_len),
      .fate       (fate),
      .fold_en    (fold_en),
      .reached    (count_reached)
   );

   assign word_accept  = (fate == FATE_ACCEPT);
   assign word_discard = (fate == FATE_DISCARD);

   bcrc_engine #(.CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_seed (burst_start),
      .fold_en   (fold_en),
      .word_in   (word_data),
      .crc_q     (crc_value)
   );

   bcrc_err_track #(
      .CRC_W(CRC_W), .BURST_W(BURST_W), .ERR_W(ERR_W),
      .ICRC_BIT(ICRC_BIT), .ABORT_BIT(ABORT_BIT)
   ) u_err (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .cmd_end     (cmd_end),
      .burst_start (burst_start),
      .crc_cap     (crc_cap),
      .host_crc    (host_crc),
      .crc_local   (crc_value),
      .mismatch_q  (burst_mismatch),
      .sticky_q    (err_sticky),
      .first_q     (first_err_burst),
      .err_q       (err_reg)
   );
endmodule

// File: rtl/bcrc_chk.sv
module bcrc_chk #(
   parameter int unsigned CRC_W     = 16,
   parameter logic [CRC_W-1:0] SEED = 16'h4ABA,
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned BURST_W   = 4,
   parameter int unsigned ERR_W     = 8,
   parameter int unsigned ICRC_BIT  = 7,
   parameter int unsigned ABORT_BIT = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_start,
   input logic               cmd_end,
   input logic               burst_start,
   input logic               dir_out,
   input logic [CNT_W-1:0]   xfer_len,
   input logic               word_valid,
   input logic               term_ack,
   input logic [CRC_W-1:0]   word_data,
   input logic               crc_cap,
   input logic [CRC_W-1:0]   host_crc,
   input logic [CRC_W-1:0]   crc_value,
   input logic               word_accept,
   input logic               word_discard,
   input logic               count_reached,
   input logic               burst_mismatch,
   input logic               err_sticky,
   input logic [BURST_W-1:0] first_err_burst,
   input logic [ERR_W-1:0]   err_reg
);
   localparam logic [ERR_W-1:0] FLAG_MASK = (ERR_W'(1) << ICRC_BIT) | (ERR_W'(1) << ABORT_BIT);

   // R2
   seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_start && !word_valid) |=> (crc_value == SEED));

   // R3
   term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && term_ack && !burst_start) |=> $stable(crc_value));

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!word_valid && !burst_start) |=> $stable(crc_value));

   // R8
   fate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(word_accept && word_discard));

   // R3
   term_no_fate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_ack |-> (!word_accept && !word_discard));

   // R4
   mismatch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_cap && !cmd_start && host_crc != crc_value) |=> burst_mismatch);

   // R5
   sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky && !cmd_start) |=> err_sticky);

   // R6
   first_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky && !cmd_start) |=> $stable(first_err_burst));

   // R7
   err_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_reg & ~FLAG_MASK) == '0) && (err_reg[ICRC_BIT] == err_reg[ABORT_BIT]));

   // R7
   cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> (err_reg == '0 && !err_sticky));
endmodule

bind burst_crc_chk bcrc_chk #(
   .CRC_W(CRC_W), .SEED(SEED), .CNT_W(CNT_W), .BURST_W(BURST_W),
   .ERR_W(ERR_W), .ICRC_BIT(ICRC_BIT), .ABORT_BIT(ABORT_BIT)
) u_chk (.*);

// File: tb/test_burst_crc_chk.sv
module test_burst_crc_chk;
   localparam logic [15:0] SEED = 16'h4ABA;
   localparam logic [15:0] POLY = 16'h1021;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 0, cmd_end = 0, burst_start = 0, dir_out = 0;
   logic [11:0] xfer_len = 12'd0;
   logic        word_valid = 0, term_ack = 0, crc_cap = 0;
   logic [15:0] word_data = '0, host_crc = '0;
   logic [15:0] crc_value;
   logic        word_accept, word_discard, count_reached, burst_mismatch, err_sticky;
   logic [3:0]  first_err_burst;
   logic [7:0]  err_reg;

   int checks = 0;
   int failures = 0;
   logic [15:0] exp_crc;

   always #4 clk = ~clk;

   burst_crc_chk i_burst_crc_chk (.*);

   function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [15:0] d);
      logic [15:0] r;
      r = c ^ d;
      for (int k = 0; k < 16; k++) r = r[15] ? ((r << 1) ^ POLY) : (r << 1);
      return r;
   endfunction

   function automatic logic [15:0] pat_word(input int p, input int i);
      case (p % 4)
         0: return 16'h0001 << (i % 16);
         1: return 16'hFFFF ^ (16'h0001 << (i % 16));
         2: return 16'(i * 16'h1357 + 16'h00A5);
         default: return {8'(i), 8'(~i)};
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic do_cmd_start();
      cmd_start = 1; tick(); cmd_start = 0;
      chk("R5 cmd_start clears sticky", 32'(err_sticky), 0);
      chk("R7 cmd_start clears err_reg", 32'(err_reg), 0);
   endtask

   task automatic do_burst_start();
      burst_start = 1; tick(); burst_start = 0;
      exp_crc = SEED;
      chk("R2 seed load", 32'(crc_value), 32'(SEED));
   endtask

   task automatic send_word(input logic [15:0] d, input logic acc, input logic disc);
      word_valid = 1; word_data = d; #1;
      chk("R8/R9 word_accept", 32'(word_accept), 32'(acc));
      chk("R8 word_discard", 32'(word_discard), 32'(disc));
      tick(); word_valid = 0;
      exp_crc = ref_step(exp_crc, d);
      chk("R1 crc update", 32'(crc_value), 32'(exp_crc));
   endtask

   task automatic end_burst(input logic [15:0] h, input logic exp_mis);
      crc_cap = 1; host_crc = h; tick(); crc_cap = 0;
      chk("R4 mismatch pulse", 32'(burst_mismatch), 32'(exp_mis));
      tick();
      chk("R4 mismatch one cycle", 32'(burst_mismatch), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R10 reset state
      chk("R10 crc reset", 32'(crc_value), 32'(SEED));
      chk("R10 mismatch reset", 32'(burst_mismatch), 0);
      chk("R10 sticky reset", 32'(err_sticky), 0);
      chk("R10 first reset", 32'(first_err_burst), 0);
      chk("R10 err_reg reset", 32'(err_reg), 0);
      rst_n = 1;
      tick();

      // R1 single-bit sweep from the seed
      xfer_len = 12'd4000;
      do_cmd_start();
      for (int b = 0; b < 16; b++) begin
         do_burst_start();
         send_word(16'h0001 << b, 1, 0);
      end

      // R1/R4 pattern and length sweep with clean closes
      for (int p = 0; p < 4; p++) begin
         for (int len = 0; len < 7; len++) begin
            do_cmd_start();
            do_burst_start();
            for (int i = 0; i < len; i++) send_word(pat_word(p, i), 1, 0);
            end_burst(exp_crc, 0);
            chk("R5 clean burst no sticky", 32'(err_sticky), 0);
         end
      end

      // R2 seed and word in the same cycle
      burst_start = 1; word_valid = 1; word_data = 16'hC0DE;
      tick(); burst_start = 0; word_valid = 0;
      exp_crc = ref_step(SEED, 16'hC0DE);
      chk("R2 seed then word", 32'(crc_value), 32'(exp_crc));

      // R3 terminating strobe edge ignored
      do_cmd_start();
      xfer_len = 12'd1;
      do_burst_start();
      word_valid = 1; term_ack = 1; word_data = 16'h1234; #1;
      chk("R3 no accept", 32'(word_accept), 0);
      chk("R3 no discard", 32'(word_discard), 0);
      tick(); word_valid = 0; term_ack = 0;
      chk("R3 crc unchanged", 32'(crc_value), 32'(SEED));
      chk("R3 count unchanged", 32'(count_reached), 0);

      // R4..R7 multi-burst command: fail at 2 and 4
      do_cmd_start();
      xfer_len = 12'd4000;
      for (int bi = 1; bi <= 5; bi++) begin
         do_burst_start();
         for (int i = 0; i < 3; i++) send_word(pat_word(bi, i + bi), 1, 0);
         end_burst((bi == 2 || bi == 4) ? ~exp_crc : exp_crc, (bi == 2 || bi == 4));
         chk("R5 sticky after burst", 32'(err_sticky), (bi >= 2) ? 1 : 0);
         if (bi >= 2) chk("R6 first failing burst", 32'(first_err_burst), 2);
      end
      chk("R7 err_reg before end", 32'(err_reg), 0);
      cmd_end = 1; tick(); cmd_end = 0;
      chk("R7 err_reg bits 7 and 2", 32'(err_reg), 32'h84);
      do_cmd_start();
      chk("R6 first cleared", 32'(first_err_burst), 0);

      // R7 clean command reports zero
      do_burst_start();
      send_word(16'hAAAA, 1, 0);
      end_burst(exp_crc, 0);
      cmd_end = 1; tick(); cmd_end = 0;
      chk("R7 clean command err_reg", 32'(err_reg), 0);

      // R8/R9 outbound surplus words across lengths
      for (int len = 1; len < 6; len++) begin
         dir_out = 1; xfer_len = 12'(len);
         do_cmd_start();
         do_burst_start();
         for (int i = 0; i < len + 3; i++) begin
            chk("R9 count_reached", 32'(count_reached), (i >= len) ? 1 : 0);
            send_word(pat_word(len, i), (i < len), (i >= len));
         end
         end_burst(exp_crc, 0);
      end

      // R9 inbound words always accepted
      dir_out = 0; xfer_len = 12'd3;
      do_cmd_start();
      do_burst_start();
      for (int i = 0; i < 6; i++) send_word(pat_word(2, i), 1, 0);
      chk("R9 inbound reached", 32'(count_reached), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule